// File: doc/BRIEF.md
# Synchronous Receiver Sync-Hunt Front End

This block sits at the serial input of a character-oriented synchronous receiver. It takes a receive clock and a data line, both asynchronous to the system clock. It synchronizes them and takes one data bit on each rising edge of the receive clock. It then works out where characters begin. The framing comes from one of two sources. In the two internal modes the block compares the newest received bits with a programmed sync pattern. In external mode a framing strobe on the shared sync pin supplies the boundary instead.

Until sync is found, the block stays in the hunt state. Once framed, it groups every eight sampled bits into a character and presents it with a one-cycle valid strobe. The sync/hunt status bit shows whether the receiver is still hunting. Any change of that bit raises a sticky flag, which stays set until it is acknowledged. In the internal modes the sync pin is an output that marks pattern matches. In external mode the pin is an input.

Top module: `synhunt_rx`

## Requirements
- R1: During and directly after reset, hunt_stat_o is 1, char_vld_o is 0 and stat_chg_o is 0.
- R2: A data bit is taken at each synchronized rising edge of rxc_i. Bits arrive least significant first, so the earliest bit of a character lands in char_o bit 0.
- R3: With mode_i = 2'b00 (monosync), a hunting receiver compares the latest 8 bits with pat_i[7:0]. A match ends the hunt, the next 8 bits form the first character, and the matching pattern is not delivered as a character.
- R4: With mode_i = 2'b01 (bisync), a hunting receiver compares the latest 16 bits with pat_i. pat_i[7:0] is the first-received sync byte and pat_i[15:8] is the second. A match ends the hunt in the same way as R3.
- R5: In both internal modes, sync_oe_o is 1. sync_out_n_o goes low for the bit period that follows each sample at which the compare window matches. It does this whether the receiver is hunting or framed and whether or not the match falls on a character boundary. A window that matches on consecutive samples gives one continuous low pulse.
- R6: With mode_i[1] = 1 (external), sync_oe_o is 0 and sync_out_n_o stays 1. A falling edge on sync_n_i while hunting ends the hunt. The first character's bit 0 is the bit taken at the last rxc_i rising edge before that falling edge.
- R7: In external mode, a framed receiver stays framed while sync_n_i is held low. A rising edge on sync_n_i puts it back into hunt.
- R8: A framed receiver delivers one character for every 8 samples. char_vld_o is high for exactly one system clock per character.
- R9: A one-cycle pulse on hunt_i sets hunt_stat_o from the next cycle on and discards any partly assembled character. No character is delivered while hunting. In external mode a hunt pulse while sync_n_i stays low keeps the receiver hunting.
- R10: stat_chg_o is set whenever hunt_stat_o changes and stays set until a stat_ack_i pulse clears it. If a new change and an acknowledge coincide, the change wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Framing mode: 00 monosync, 01 bisync, 1x external |
| pat_i | input | 16 | Sync pattern, first-received byte in the low half |
| hunt_i | input | 1 | Hunt command, one-cycle pulse |
| rxc_i | input | 1 | Receive clock, asynchronous |
| rxd_i | input | 1 | Serial receive data |
| sync_n_i | input | 1 | Sync pin input value, active low (used in external mode) |
| sync_out_n_o | output | 1 | Sync pin drive value, low while a match is shown |
| sync_oe_o | output | 1 | Sync pin output enable (internal modes) |
| char_o | output | 8 | Assembled character |
| char_vld_o | output | 1 | One-cycle strobe for char_o |
| hunt_stat_o | output | 1 | Sync/hunt status, 1 while hunting |
| stat_chg_o | output | 1 | Sticky flag: status bit changed |
| stat_ack_i | input | 1 | Clears stat_chg_o |

## Verification
The checks assume that rxc_i stays at each level for several system clocks. They also assume that, in external mode, sync_n_i never changes within the few cycles around a synchronized receive-clock edge, and that mode_i and pat_i change only while reset is held. The stimulus meets these conditions by construction. Each bit period is sixteen system clocks. The sync input is moved four clocks after the receive-clock rise, well away from the next sample. The mode and pattern are set only at the start of a reset session. Random data bits fill the gaps around directed sync patterns, hunt pulses and acknowledges.

// File: rtl/synhunt_pkg.sv
package synhunt_pkg;

   typedef enum logic [1:0] {
      SH_MONO   = 2'b00,
      SH_BISYNC = 2'b01,
      SH_EXT    = 2'b10,
      SH_EXT_B  = 2'b11
   } sh_mode_e;

   function automatic logic sh_is_ext(input sh_mode_e m);
      return (m == SH_EXT) || (m == SH_EXT_B);
   endfunction

endpackage

// File: rtl/synhunt_sync.sv
// Multi-bit level synchronizer, depth chosen by parameter.
module synhunt_sync #(
   parameter int              W       = 3,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_depth
      $error("synhunt_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      logic [W-1:0] q;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= g_stg[s-1].q;
         end
      end
   end

   assign q_o = g_stg[STAGES-1].q;

endmodule

// File: rtl/synhunt_shifter.sv
// Bit history and sync pattern comparator.
module synhunt_shifter
   import synhunt_pkg::*;
#(
   parameter int CHAR_W    = 8,
   parameter bit BISYNC_EN = 1'b1,
   localparam int PAT_W    = 2 * CHAR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_i,
   input  logic              bit_i,
   input  sh_mode_e          mode_i,
   input  logic [PAT_W-1:0]  pat_i,
   output logic              hit_o,
   output logic              match_q_o,
   output logic [CHAR_W-1:0] newest_o
);

   logic [PAT_W-2:0] hist_q;
   logic [PAT_W-1:0] hist_d;
   logic             mono_hit;
   logic             bi_hit;
   logic             match_q;

   assign hist_d   = {bit_i, hist_q};
   assign newest_o = hist_d[PAT_W-1 -: CHAR_W];
   assign mono_hit = (hist_d[PAT_W-1 -: CHAR_W] == pat_i[CHAR_W-1:0]);

   if (BISYNC_EN) begin : g_bisync
      assign bi_hit = (hist_d == pat_i);
   end else begin : g_mono_only
      assign bi_hit = 1'b0;
   end

   always_comb begin
      unique case (mode_i)
         SH_MONO:   hit_o = mono_hit;
         SH_BISYNC: hit_o = bi_hit;
         default:   hit_o = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q  <= '0;
         match_q <= 1'b0;
      end else if (sample_i) begin
         hist_q  <= hist_d[PAT_W-1:1];
         match_q <= hit_o;
      end
   end

   assign match_q_o = match_q;

endmodule

// File: rtl/synhunt_framer.sv
// Hunt state, character counter, character output and status flag.
module synhunt_framer #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_i,
   input  logic              hit_i,
   input  logic              ext_mode_i,
   input  logic              sync_n_i,
   input  logic              hunt_cmd_i,
   input  logic              ack_i,
   input  logic [CHAR_W-1:0] newest_i,
   output logic [CHAR_W-1:0] char_o,
   output logic              char_vld_o,
   output logic              hunting_o,
   output logic              chg_o
);

   localparam int               CNT_W   = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CHAR_W - 1);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic              sync_n_q;
   logic              hunting_q, hunting_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [CHAR_W-1:0] char_q;
   logic              vld_q;
   logic              chg_q;
   logic              ext_fall, ext_rise;
   logic              acquire, lose, set_hunt, emit;

   assign ext_fall = ext_mode_i &  sync_n_q & ~sync_n_i;
   assign ext_rise = ext_mode_i & ~sync_n_q &  sync_n_i;
   assign acquire  = hunting_q & ((~ext_mode_i & sample_i & hit_i) | ext_fall);
   assign lose     = ~hunting_q & ext_rise;
   assign set_hunt = hunt_cmd_i | lose;
   assign emit     = ~hunting_q & sample_i & (cnt_q == CNT_MAX) & ~set_hunt;

   always_comb begin
      hunting_d = hunting_q;
      cnt_d     = cnt_q;
      if (set_hunt) begin
         hunting_d = 1'b1;
         cnt_d     = '0;
      end else if (acquire) begin
         hunting_d = 1'b0;
         cnt_d     = ext_fall ? CNT_ONE : '0;
      end else if (!hunting_q && sample_i) begin
         cnt_d     = (cnt_q == CNT_MAX) ? '0 : cnt_q + CNT_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_n_q  <= 1'b1;
         hunting_q <= 1'b1;
         cnt_q     <= '0;
         char_q    <= '0;
         vld_q     <= 1'b0;
         chg_q     <= 1'b0;
      end else begin
         sync_n_q  <= sync_n_i;
         hunting_q <= hunting_d;
         cnt_q     <= cnt_d;
         vld_q     <= emit;
         if (emit) char_q <= newest_i;
         if (hunting_d != hunting_q) chg_q <= 1'b1;
         else if (ack_i)             chg_q <= 1'b0;
      end
   end

   assign char_o     = char_q;
   assign char_vld_o = vld_q;
   assign hunting_o  = hunting_q;
   assign chg_o      = chg_q;

endmodule

// File: rtl/synhunt_rx.sv
module synhunt_rx
   import synhunt_pkg::*;
#(
   parameter int CHAR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit BISYNC_EN   = 1'b1,
   localparam int PAT_W      = 2 * CHAR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic [PAT_W-1:0]  pat_i,
   input  logic              hunt_i,
   input  logic              rxc_i,
   input  logic              rxd_i,
   input  logic              sync_n_i,
   output logic              sync_out_n_o,
   output logic              sync_oe_o,
   output logic [CHAR_W-1:0] char_o,
   output logic              char_vld_o,
   output logic              hunt_stat_o,
   output logic              stat_chg_o,
   input  logic              stat_ack_i
);

   if (CHAR_W < 2) begin : g_bad_char
      $error("synhunt_rx: CHAR_W must be at least 2");
   end

   sh_mode_e   mode;
   logic       ext_mode;
   logic [2:0] pins_s;
   logic       rxc_s, rxd_s, sync_n_s;
   logic       rxc_prev_q;
   logic       sample;
   logic       hit;
   logic       match_q;
   logic [CHAR_W-1:0] newest;

   assign mode     = sh_mode_e'(mode_i);
   assign ext_mode = sh_is_ext(mode);

   synhunt_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sync_n_i, rxd_i, rxc_i}),
      .q_o   (pins_s)
   );

   assign {sync_n_s, rxd_s, rxc_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rxc_prev_q <= 1'b0;
      else        rxc_prev_q <= rxc_s;
   end

   assign sample = rxc_s & ~rxc_prev_q;

   synhunt_shifter #(
      .CHAR_W    (CHAR_W),
      .BISYNC_EN (BISYNC_EN)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_i  (sample),
      .bit_i     (rxd_s),
      .mode_i    (mode),
      .pat_i     (pat_i),
      .hit_o     (hit),
      .match_q_o (match_q),
      .newest_o  (newest)
   );

   synhunt_framer #(
      .CHAR_W (CHAR_W)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_i   (sample),
      .hit_i      (hit),
      .ext_mode_i (ext_mode),
      .sync_n_i   (sync_n_s),
      .hunt_cmd_i (hunt_i),
      .ack_i      (stat_ack_i),
      .newest_i   (newest),
      .char_o     (char_o),
      .char_vld_o (char_vld_o),
      .hunting_o  (hunt_stat_o),
      .chg_o      (stat_chg_o)
   );

   assign sync_oe_o    = ~ext_mode;
   assign sync_out_n_o = ~(match_q & ~ext_mode);

endmodule

// File: rtl/synhunt_rx_chk.sv
module synhunt_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_i,
   input logic       hunt_i,
   input logic       sync_out_n_o,
   input logic       sync_oe_o,
   input logic       char_vld_o,
   input logic       hunt_stat_o,
   input logic       stat_chg_o,
   input logic       stat_ack_i
);

   AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      char_vld_o |=> !char_vld_o);  // R8

   AST_NO_CHAR_HUNTING: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_stat_o |-> !char_vld_o);  // R9

   AST_HUNT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_i |=> hunt_stat_o);  // R9

   AST_CHG_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hunt_stat_o != $past(hunt_stat_o)) |-> stat_chg_o);  // R10

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      stat_ack_i |=> (!stat_chg_o || (hunt_stat_o != $past(hunt_stat_o))));  // R10

   AST_EXT_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mode_i[1] |-> (!sync_oe_o && sync_out_n_o));  // R6

endmodule

bind synhunt_rx synhunt_rx_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_i       (mode_i),
   .hunt_i       (hunt_i),
   .sync_out_n_o (sync_out_n_o),
   .sync_oe_o    (sync_oe_o),
   .char_vld_o   (char_vld_o),
   .hunt_stat_o  (hunt_stat_o),
   .stat_chg_o   (stat_chg_o),
   .stat_ack_i   (stat_ack_i)
);

// File: tb/synhunt_rx_bench.sv
module synhunt_rx_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  mode_i;
   logic [15:0] pat_i;
   logic        hunt_i, rxc_i, rxd_i, sync_n_i, stat_ack_i;
   logic        sync_out_n_o, sync_oe_o, char_vld_o, hunt_stat_o, stat_chg_o;
   logic [7:0]  char_o;

   int n_chk  = 0;
   int n_fail = 0;

   // bench model state
   logic [14:0] m_hist;
   logic        m_hunt, m_prev, m_chg;
   int          m_cnt, m_edges;
   logic [1:0]  cur_mode;
   logic [15:0] cur_pat;
   logic [7:0]  exp_q[$];
   logic [7:0]  got_q[$];
   int          got_edges;
   logic        prev_out;

   always #4 clk = ~clk;

   synhunt_rx u_synhunt_rx (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pat_i(pat_i), .hunt_i(hunt_i),
      .rxc_i(rxc_i), .rxd_i(rxd_i), .sync_n_i(sync_n_i),
      .sync_out_n_o(sync_out_n_o), .sync_oe_o(sync_oe_o),
      .char_o(char_o), .char_vld_o(char_vld_o), .hunt_stat_o(hunt_stat_o),
      .stat_chg_o(stat_chg_o), .stat_ack_i(stat_ack_i)
   );

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_out = 1'b1;
      end else begin
         if (char_vld_o) got_q.push_back(char_o);
         if (sync_oe_o) begin
            if (prev_out && !sync_out_n_o) got_edges++;
            prev_out = sync_out_n_o;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   function automatic logic exp_hit(input logic [15:0] h);
      if (cur_mode == 2'b00) return h[15:8] == cur_pat[7:0];
      if (cur_mode == 2'b01) return h == cur_pat;
      return 1'b0;
   endfunction

   task automatic model_sample(input logic b);
      logic [15:0] h;
      logic        hit;
      h = {b, m_hist};
      m_hist = h[15:1];
      hit = exp_hit(h);
      if (hit && !m_prev) m_edges++;
      m_prev = hit;
      if (m_hunt) begin
         if (hit) begin m_hunt = 1'b0; m_cnt = 0; m_chg = 1'b1; end
      end else begin
         m_cnt++;
         if (m_cnt == 8) begin exp_q.push_back(h[15:8]); m_cnt = 0; end
      end
   endtask

   task automatic begin_session(input logic [1:0] m, input logic [15:0] p);
      @(negedge clk);
      rst_n = 1'b0; rxc_i = 1'b0; rxd_i = 1'b0; sync_n_i = 1'b1;
      hunt_i = 1'b0; stat_ack_i = 1'b0; mode_i = m; pat_i = p;
      cur_mode = m; cur_pat = p;
      m_hist = '0; m_hunt = 1'b1; m_prev = 1'b0; m_chg = 1'b0; m_cnt = 0; m_edges = 0;
      exp_q.delete(); got_q.delete(); got_edges = 0;
      repeat (3) @(negedge clk);
      check("R1 hunt in reset", hunt_stat_o, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 hunt", hunt_stat_o, 1);
      check("R1 vld", char_vld_o, 0);
      check("R1 chg", stat_chg_o, 0);
      check(m[1] ? "R6 oe" : "R5 oe", sync_oe_o, m[1] ? 0 : 1);
   endtask

   // act: 0 none, 1 drive sync low, 2 release sync high
   task automatic send_bit(input logic b, input int act, input string req);
      @(negedge clk);
      rxd_i = b;
      repeat (7) @(negedge clk);
      rxc_i = 1'b1;
      model_sample(b);
      repeat (4) @(negedge clk);
      if (act == 1) begin
         sync_n_i = 1'b0;
         if (m_hunt) begin m_hunt = 1'b0; m_cnt = 1; m_chg = 1'b1; end
      end else if (act == 2) begin
         sync_n_i = 1'b1;
         if (!m_hunt) begin m_hunt = 1'b1; m_cnt = 0; m_chg = 1'b1; end
      end
      repeat (4) @(negedge clk);
      rxc_i = 1'b0;
      check(req, hunt_stat_o, m_hunt);
      check("R10 flag", stat_chg_o, m_chg);
   endtask

   task automatic send_byte(input logic [7:0] v, input string req);
      for (int i = 0; i < 8; i++) send_bit(v[i], 0, req);
   endtask

   task automatic send_rand(input int n, input string req);
      for (int i = 0; i < n; i++) send_bit(1'($urandom_range(0, 1)), 0, req);
   endtask

   task automatic do_hunt();
      @(negedge clk); hunt_i = 1'b1;
      @(negedge clk); hunt_i = 1'b0;
      if (!m_hunt) m_chg = 1'b1;
      m_hunt = 1'b1; m_cnt = 0;
      @(negedge clk);
      check("R9 hunt cmd", hunt_stat_o, 1);
      check("R10 flag after hunt", stat_chg_o, m_chg);
   endtask

   task automatic do_ack();
      @(negedge clk); stat_ack_i = 1'b1;
      @(negedge clk); stat_ack_i = 1'b0;
      m_chg = 1'b0;
      @(negedge clk);
      check("R10 ack", stat_chg_o, 0);
   endtask

   task automatic finish_session(input string tag);
      repeat (20) @(negedge clk);
      check({tag, " R8 char count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         check({tag, " R2 R8 char"}, got_q[i], exp_q[i]);
      if (!cur_mode[1]) check({tag, " R5 sync pulses"}, got_edges, m_edges);
      else              check({tag, " R6 pin idle"}, {sync_oe_o, sync_out_n_o}, 2'b01);
   endtask

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0;

      // monosync
      begin_session(2'b00, 16'h00A7);
      send_rand(20, "R3");
      send_byte(8'hA7, "R3");
      check("R3 acquired", hunt_stat_o, 0);
      do_ack();
      for (int k = 0; k < 6; k++) send_byte(8'($urandom_range(0, 255)), "R3");
      send_rand(4, "R5");
      send_byte(8'hA7, "R5");
      send_byte(8'hA7, "R5");
      send_rand(3, "R9");
      do_hunt();
      send_rand(10, "R9");
      send_byte(8'hA7, "R3");
      for (int k = 0; k < 3; k++) send_byte(8'($urandom_range(0, 255)), "R3");
      finish_session("mono");

      // bisync
      begin_session(2'b01, 16'h5A3C);
      send_rand(24, "R4");
      send_byte(8'h3C, "R4");
      send_byte(8'h5A, "R4");
      check("R4 acquired", hunt_stat_o, 0);
      for (int k = 0; k < 5; k++) send_byte(8'($urandom_range(0, 255)), "R4");
      do_hunt();
      send_byte(8'h3C, "R4");
      send_byte(8'h11, "R4");
      send_byte(8'h3C, "R4");
      send_byte(8'h5A, "R4");
      for (int k = 0; k < 3; k++) send_byte(8'($urandom_range(0, 255)), "R4");
      finish_session("bisync");

      // external
      begin_session(2'b10, 16'h0000);
      send_rand(30, "R6");
      send_byte(8'h96, "R6");
      send_bit(1'($urandom_range(0, 1)), 0, "R6");
      send_bit(1'($urandom_range(0, 1)), 1, "R6");
      check("R6 acquired", hunt_stat_o, 0);
      send_rand(40, "R7");
      send_bit(1'($urandom_range(0, 1)), 2, "R7");
      check("R7 lost", hunt_stat_o, 1);
      send_rand(12, "R7");
      send_byte(8'h96, "R6");
      send_bit(1'b1, 0, "R6");
      send_bit(1'b0, 1, "R6");
      send_rand(24, "R7");
      do_hunt();
      send_rand(12, "R9");
      do_ack();
      finish_session("ext");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule